// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit single-precision operands, accompanied by a valid strobe, and returns their product one clock later as a 32-bit word with a matching valid strobe. Sign, exponent and significand are worked out on separate paths. They are packed into the result word only after the significand product has been normalized. Two flags report exponent overflow and exponent underflow.

Each operand's 24-bit significand is its 23 stored fraction bits with an implicit leading 1 placed above them. The two significands feed a divide-and-conquer (Karatsuba) unsigned multiplier. That multiplier splits each operand in halves recursively until it reaches a small leaf width, and it needs three sub-products per level instead of four.

All logic from the operands to the result is combinational. It ends in a single output register, which loads only on cycles where the input strobe is high.

Rounding is by truncation. Denormal inputs, NaN handling and round-to-nearest are outside the block. Callers should treat an operand with a zero exponent field and a nonzero fraction as undefined.

Top module: `fpmul_top`

## Requirements
- R1: The word layout is bit 31 = sign, bits 30:23 = biased exponent (bias 127), bits 22:0 = fraction. The result sign is the XOR of the two operand signs.
- R2: When bit 47 of the 48-bit product of the two 24-bit significands (hidden 1 prepended) is clear, the result exponent is expA + expB - 127 and the result fraction is product bits 45:23.
- R3: When product bit 47 is set, the result exponent is expA + expB - 126 and the result fraction is product bits 46:24.
- R4: Product bits below the selected fraction field are discarded. This is truncation, with no rounding increment.
- R5: If either operand has bits 30:0 all zero, the result is a zero carrying the R1 sign, and neither flag is raised.
- R6: If the final biased exponent is 255 or more, the overflow flag is set and the result is signed infinity (exponent 255, fraction 0).
- R7: If the final biased exponent is 0 or less, the underflow flag is set and the result is signed zero. Overflow and underflow are never set together.
- R8: The output valid strobe is high exactly one clock after each cycle in which the input strobe is high, and is low otherwise. Result and flags hold their values while no new operation is captured.
- R9: While reset is asserted, the result, the flags and the output valid are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands are present this cycle |
| opA | input | 32 | First single-precision operand |
| opB | input | 32 | Second single-precision operand |
| outValid | output | 1 | Result is present this cycle |
| result | output | 32 | Single-precision product |
| overflow | output | 1 | Exponent overflow, result is infinity |
| underflow | output | 1 | Exponent underflow, result is zero |

## Verification
The block keeps only one cycle of state, so any fault in the significand core, the normalization select or the exponent arithmetic shows up in the result word on the first strobe after the faulty operands are applied. A wrong partial product inside the recursive multiplier changes only certain bit patterns. The stimulus therefore combines exact products, all-ones fractions and a spread of pseudo-random fractions. Faults in the exponent limits show only at the exact boundary values 0, 1, 254 and 255, so each of those values is driven, including one that reaches 255 through the normalization increment alone.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXT_W  = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int LEAF_W = 3;

  typedef struct packed {
    logic loadResult;
  } ctrlStrobes_t;
endpackage

// File: rtl/karatsuba_mul.sv
module karatsuba_mul #(
  parameter int WIDTH  = 24,
  parameter int LEAF_W = 3
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  generate
    if (WIDTH <= LEAF_W || WIDTH < 4) begin : g_leaf
      assign prod = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
    end else begin : g_split
      localparam int LO  = WIDTH / 2;
      localparam int HI  = WIDTH - LO;
      localparam int MID = HI + 1;

      logic [LO-1:0]    aLo, bLo;
      logic [HI-1:0]    aHi, bHi;
      logic [MID-1:0]   aSum, bSum;
      logic [2*LO-1:0]  pLo;
      logic [2*HI-1:0]  pHi;
      logic [2*MID-1:0] pMid;
      logic [PW-1:0]    pLoX, pHiX, pMidX, crossX;

      assign aLo  = a[LO-1:0];
      assign bLo  = b[LO-1:0];
      assign aHi  = a[WIDTH-1:LO];
      assign bHi  = b[WIDTH-1:LO];
      assign aSum = {1'b0, aHi} + {{(MID-LO){1'b0}}, aLo};
      assign bSum = {1'b0, bHi} + {{(MID-LO){1'b0}}, bLo};

      karatsuba_mul #(.WIDTH(LO),  .LEAF_W(LEAF_W)) lo_i  (.a(aLo),  .b(bLo),  .prod(pLo));
      karatsuba_mul #(.WIDTH(HI),  .LEAF_W(LEAF_W)) hi_i  (.a(aHi),  .b(bHi),  .prod(pHi));
      karatsuba_mul #(.WIDTH(MID), .LEAF_W(LEAF_W)) mid_i (.a(aSum), .b(bSum), .prod(pMid));

      assign pLoX   = {{(PW-2*LO){1'b0}}, pLo};
      assign pHiX   = {{(PW-2*HI){1'b0}}, pHi};
      assign pMidX  = {{(PW-2*MID){1'b0}}, pMid};
      assign crossX = pMidX - pHiX - pLoX;
      assign prod   = (pHiX << (2 * LO)) + (crossX << LO) + pLoX;
    end
  endgenerate
endmodule

// File: rtl/fpmul_control.sv
module fpmul_control
  import fpmul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t ctrl,
  output logic         outValid
);
  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  always_comb begin
    ctrl.loadResult = inValid;
  end

  assign outValid = validQ;
endmodule

// File: rtl/fpmul_datapath.sv
module fpmul_datapath
  import fpmul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] resultQ,
  output logic              ovfQ,
  output logic              unfQ
);
  logic              signR;
  logic [EXP_W-1:0]  expA, expB;
  logic [SIG_W-1:0]  sigA, sigB;
  logic [PROD_W-1:0] sigProd;
  logic              normHi;
  logic [FRAC_W-1:0] fracR;
  logic signed [EXT_W-1:0] expR;
  logic              anyZero;
  logic [WORD_W-1:0] resultD;
  logic              ovfD, unfD;

  assign signR   = opA[WORD_W-1] ^ opB[WORD_W-1];
  assign expA    = opA[WORD_W-2:FRAC_W];
  assign expB    = opB[WORD_W-2:FRAC_W];
  assign sigA    = {1'b1, opA[FRAC_W-1:0]};
  assign sigB    = {1'b1, opB[FRAC_W-1:0]};
  assign anyZero = (opA[WORD_W-2:0] == '0) || (opB[WORD_W-2:0] == '0);

  karatsuba_mul #(.WIDTH(SIG_W), .LEAF_W(LEAF_W)) sig_mul_i (
    .a(sigA), .b(sigB), .prod(sigProd)
  );

  assign normHi = sigProd[PROD_W-1];
  assign fracR  = normHi ? sigProd[PROD_W-2 -: FRAC_W] : sigProd[PROD_W-3 -: FRAC_W];
  assign expR   = $signed({2'b00, expA} + {2'b00, expB} - EXT_W'(BIAS)
                          + {{(EXT_W-1){1'b0}}, normHi});

  always_comb begin
    ovfD    = 1'b0;
    unfD    = 1'b0;
    resultD = {signR, {(WORD_W-1){1'b0}}};
    if (anyZero) begin
      resultD = {signR, {(WORD_W-1){1'b0}}};
    end else if (expR >= EXT_W'(EXP_MAX)) begin
      ovfD    = 1'b1;
      resultD = {signR, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (expR <= 0) begin
      unfD    = 1'b1;
    end else begin
      resultD = {signR, expR[EXP_W-1:0], fracR};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      ovfQ    <= 1'b0;
      unfQ    <= 1'b0;
    end else if (ctrl.loadResult) begin
      resultQ <= resultD;
      ovfQ    <= ovfD;
      unfQ    <= unfD;
    end
  end
endmodule

// File: rtl/fpmul_top.sv
module fpmul_top
  import fpmul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        outValid,
  output logic [31:0] result,
  output logic        overflow,
  output logic        underflow
);
  ctrlStrobes_t ctrl;

  fpmul_control control_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .outValid(outValid)
  );

  fpmul_datapath datapath_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .resultQ(result), .ovfQ(overflow), .unfQ(underflow)
  );
endmodule

// File: rtl/fpmul_checker.sv
module fpmul_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic        outValid,
  input logic [31:0] result,
  input logic        overflow,
  input logic        underflow
);
  assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result) && $stable(overflow) && $stable(underflow));

  assert_sign_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> result[31] == $past(opA[31] ^ opB[31]));

  assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (opA[30:0] == 31'd0 || opB[30:0] == 31'd0)
    |=> result[30:0] == 31'd0 && !overflow && !underflow);

  assert_overflow_inf_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> result[30:0] == 31'h7F80_0000);

  assert_underflow_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> result[30:0] == 31'd0 && !overflow);

  assert_reset_state_R9: assert property (@(posedge clk)
    !rstN |-> !outValid && result == 32'd0 && !overflow && !underflow);
endmodule

bind fpmul_top fpmul_checker chk_i (.*);

// File: tb/fpmul_top_tb_top.sv
module fpmul_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] result;
  logic        overflow;
  logic        underflow;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [33:0] expQ[$];
  string       tagQ[$];
  logic [33:0] lastOut = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpmul_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .overflow(overflow), .underflow(underflow)
  );

  // Reference: {overflow, underflow, result}
  function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b);
    logic        s;
    logic [47:0] p;
    logic [22:0] f;
    int          e;
    s = a[31] ^ b[31];
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    e = int'(a[30:23]) + int'(b[30:23]) - 127 + (p[47] ? 1 : 0);
    f = p[47] ? p[46:24] : p[45:23];
    if (a[30:0] == 0 || b[30:0] == 0) return {2'b00, s, 31'd0};
    if (e >= 255) return {2'b10, s, 8'hFF, 23'd0};
    if (e <= 0)   return {2'b01, s, 31'd0};
    return {2'b00, s, e[7:0], f};
  endfunction

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendOp(logic [31:0] a, logic [31:0] b, string tag);
    @(negedge clk);
    opA = a;
    opB = b;
    inValid = 1'b1;
    expQ.push_back(model(a, b));
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = 32'hDEAD_BEEF;
      opB = 32'h1234_5678;
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: scoreboard comparison and R8 valid/hold behaviour
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R8: outValid high with nothing expected (actual 1 expected 0)");
        end else begin
          check(tagQ.pop_front(), {overflow, underflow, result}, expQ.pop_front());
        end
      end else begin
        check("R8 hold", {overflow, underflow, result}, lastOut);
      end
      lastOut = {overflow, underflow, result};
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete (actual timeout expected done)");
      report();
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    repeat (3) @(negedge clk);
    check("R9 reset", {outValid, overflow, underflow, result}, 34'd0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    sendOp(32'h3F80_0000, 32'h3F80_0000, "R2 one times one");
    sendOp(32'h4000_0000, 32'h4040_0000, "R2 two times three");
    sendOp(32'h3FC0_0000, 32'h3FC0_0000, "R3 normalize 1.5*1.5");
    sendOp(32'hC000_0000, 32'h4040_0000, "R1 negative sign");
    sendOp(32'hBF80_0000, 32'hBFC0_0000, "R1 both negative");
    sendOp(32'h3FFF_FFFF, 32'h3FFF_FFFF, "R4 truncation all ones");
    sendOp(32'h3F80_0001, 32'h3F80_0001, "R4 truncation low bits");
    idle(3);
    sendOp(32'h0000_0000, 32'h4040_0000, "R5 zero operand A");
    sendOp(32'h3F80_0000, 32'h8000_0000, "R5 negative zero operand B");
    sendOp(32'h8000_0000, 32'h7F00_0000, "R5 zero beats overflow");
    sendOp(32'h7F00_0000, 32'h7F00_0000, "R6 overflow large");
    sendOp(32'h7F00_0000, 32'hC000_0000, "R6 overflow exact 255 negative");
    sendOp(32'h7F00_0000, 32'h3F80_0000, "R6 exponent 254 no overflow");
    sendOp(32'h7F40_0000, 32'h3FC0_0000, "R6 R3 overflow via normalize");
    idle(2);
    sendOp(32'h0080_0000, 32'h0080_0000, "R7 underflow deep");
    sendOp(32'h0080_0000, 32'hBF00_0000, "R7 underflow exact 0 negative");
    sendOp(32'h0080_0000, 32'h3F80_0000, "R7 exponent 1 no underflow");
    sendOp(32'h0080_0000, 32'h3F7F_FFFF, "R7 R2 underflow without normalize");
    idle(4);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = {lfsr[31], 8'(8'd110 + {3'b000, lfsr[27:23]}), lfsr[22:0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = lfsr ^ (lfsr << 13) ^ (lfsr >> 7);
      b = {lfsr[31], 8'(8'd110 + {3'b000, lfsr[27:23]}), lfsr[22:0]};
      sendOp(a, b, "R2 R3 R4 random");
      if (i % 7 == 3) idle(1);
    end
    idle(5);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R8: %0d results missing (actual %0d expected 0)", expQ.size(), expQ.size());
    end
    finished = 1;
    report();
  end
endmodule